// File: doc/BRIEF.md
# Hardware-Sequenced Serial Flash Cycle Engine

This block runs complete serial-flash transactions on its own. Software names an abstract cycle kind, loads an address and, for writes, a data buffer of up to 64 bytes. It then sets a start bit. The engine builds the whole single-lane SPI exchange: the opcode, the address bytes, any dummy byte and the data. Before any write-type cycle it sends a write-enable frame. After any write-type cycle it keeps reading the flash status byte until the flash reports it is idle. Only then does it flag completion.

Three sticky outcomes are reported separately. Completion is one. A flash cycle error covers an unsupported cycle kind or a flash that stays busy too long. An access error covers a write or erase aimed at the protected address window; that cycle is refused before any pin moves. Each flag is cleared by writing a one to its clear bit. Read data lands in the same buffer, starting at index 0, and software reads it by index once the engine is idle.

Top module: `flash_cycle_engine`

## Requirements
- R1: After reset, busy, done, fcerr and ael are low, spi_cs_n is high and spi_sck is low.
- R2: A control write uses these bits:
  - bit 0 starts a cycle.
  - bits [3:1] select the kind: 0 read, 1 page write, 2 4 KB erase, 3 read ID, 4 write status, 5 read status.
  - bits [4 +: IDX_W] hold the byte count minus one.
  - bits 13, 14 and 15 clear done, fcerr and ael.

  A start bit or a buffer write that arrives while busy is ignored.
- R3: A read sends one frame: 0x0B, the address most significant byte first, one dummy byte, then count bytes. The bytes received are stored at buffer index 0 upward, and done is set. No write enable is sent.
- R4: A page write sends three frames in order. The first is 0x06 alone. The second is 0x02, the address, then count bytes taken from buffer index 0 upward. The third is a 0x05 frame that reads status bytes until bit 0 is clear. Done is set only after that frame ends.
- R5: An erase sends three frames in order: 0x06 alone, then 0x20 with three address bytes and no data, then the status poll frame of R4.
- R6: Read ID sends 0x9F and read status sends 0x05, each followed by count received bytes stored from index 0. Neither sends a write enable or a poll frame.
- R7: A write status sends 0x06 alone, then 0x01 with count bytes from the buffer, then the status poll frame.
- R8: A page write or erase whose address lies in [PROT_LO, PROT_HI] sets ael only. Busy, done and the SPI pins do not change. Reads in that window and writes just below it run normally.
- R9: Cycle kinds 6 and 7 set fcerr only, with no SPI activity.
- R10: If POLL_MAX status bytes in a row report busy, the engine sets fcerr, leaves done low, raises spi_cs_n and returns to idle.
- R11: A clear bit written as 1 clears only its own flag. A 0 leaves that flag unchanged.
- R12: Every byte count from 1 to 64 moves exactly that many data bytes.
- R13: The SPI port runs mode 0 at half the clock rate, most significant bit first. spi_sck is high only while spi_cs_n is low, and the chip select is high whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control/status register write strobe |
| ctl_wdata | input | 16 | Control word (start, kind, count-1, flag clears) |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | ADDR_W | Flash byte address |
| buf_wr | input | 1 | Data buffer write strobe (idle only) |
| buf_idx | input | IDX_W | Data buffer index for writes and reads |
| buf_wdata | input | 8 | Data buffer write byte |
| buf_rdata | output | 8 | Buffer byte at buf_idx, one cycle after it is set |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Sticky: last cycle completed |
| fcerr | output | 1 | Sticky: flash cycle error |
| ael | output | 1 | Sticky: access refused by the protected window |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench drives the block with a behavioural flash that logs each chip-select frame by opcode and byte count. That log separates the three-frame write and erase flows from the single-frame reads. Read ID and read status are run with fixed response bytes, so lost or reordered bytes show up. A sweep over every read length from 1 to 64 bytes, after a 64-byte page write of a computed pattern, exposes off-by-one errors in the count field. Addresses at both edges of the protected window, a flash that never goes idle, an unsupported kind, and starts issued while busy tell the refusal and error paths apart from the normal ones.

// File: rtl/flash_cycle_pkg.sv
package flash_cycle_pkg;
  localparam logic [2:0] CYC_READ  = 3'd0;
  localparam logic [2:0] CYC_PROG  = 3'd1;
  localparam logic [2:0] CYC_ERASE = 3'd2;
  localparam logic [2:0] CYC_RDID  = 3'd3;
  localparam logic [2:0] CYC_WRSR  = 3'd4;
  localparam logic [2:0] CYC_RDSR  = 3'd5;

  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SE4K  = 8'h20;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int CTL_GO        = 0;
  localparam int CTL_TYPE_LSB  = 1;
  localparam int CTL_CNT_LSB   = 4;
  localparam int CTL_CLR_DONE  = 13;
  localparam int CTL_CLR_FCERR = 14;
  localparam int CTL_CLR_AEL   = 15;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_CMD, S_ADDR, S_DUMMY,
    S_DIN, S_DOUT, S_END, S_PCMD, S_PREAD, S_FIN
  } seq_state_t;

  function automatic logic [7:0] opcode_of(input logic [2:0] kind);
    case (kind)
      CYC_READ:  opcode_of = OP_FREAD;
      CYC_PROG:  opcode_of = OP_PROG;
      CYC_ERASE: opcode_of = OP_SE4K;
      CYC_RDID:  opcode_of = OP_RDID;
      CYC_WRSR:  opcode_of = OP_WRSR;
      default:   opcode_of = OP_RDSR;
    endcase
  endfunction
endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
  parameter int W = 8,
  parameter int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         done,
  output logic [W-1:0] rx,
  output logic         sck,
  output logic         mosi
);
  logic          active, phase;
  logic [CW-1:0] bitn;
  logic [W-1:0]  sh_tx, sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= 1'b0;
      bitn   <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh_tx  <= tx;
          mosi   <= tx[W-1];
          phase  <= 1'b0;
          bitn   <= '0;
        end
      end else if (!phase) begin
        sck   <= 1'b1;
        sh_rx <= {sh_rx[W-2:0], miso};
        phase <= 1'b1;
      end else begin
        sck   <= 1'b0;
        phase <= 1'b0;
        if (bitn == CW'(W-1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          rx     <= sh_rx;
        end else begin
          bitn  <= bitn + CW'(1);
          sh_tx <= {sh_tx[W-2:0], 1'b0};
          mosi  <= sh_tx[W-2];
        end
      end
    end
  end
endmodule

// File: rtl/flash_data_buf.sv
module flash_data_buf #(
  parameter int DEPTH = 64,
  parameter int W = 8,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cycle_engine.sv
module flash_cycle_engine
  import flash_cycle_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUF_DEPTH = 64,
  parameter int POLL_MAX = 1024,
  parameter int unsigned PROT_LO = 32'h0000_0800,
  parameter int unsigned PROT_HI = 32'h0000_0FFF,
  parameter int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              buf_wr,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              busy,
  output logic              done,
  output logic              fcerr,
  output logic              ael,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W = $clog2(ADDR_BYTES + 1);
  localparam int PC_W = $clog2(POLL_MAX + 1);
  localparam logic [ADDR_W-1:0] PLO = PROT_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PHI = PROT_HI[ADDR_W-1:0];

  seq_state_t        state;
  logic [2:0]        kind;
  logic [ADDR_W-1:0] addr_reg, addr_q;
  logic [IDX_W-1:0]  cnt_q, idx;
  logic [AB_W-1:0]   abyte;
  logic [PC_W-1:0]   poll_cnt;
  logic              pend, hold;
  logic              sh_done;
  logic [7:0]        sh_rx, tx_byte, buf_q;
  logic              launch, byte_state, go;
  logic              req_kind_ok, req_write, req_prot, req_wren;
  logic              k_wren, k_addr;
  logic [2:0]        req_kind;

  assign busy = (state != S_IDLE);
  assign req_kind = ctl_wdata[CTL_TYPE_LSB +: 3];
  assign go = ctl_wr && ctl_wdata[CTL_GO] && (state == S_IDLE);
  assign req_kind_ok = (req_kind <= CYC_RDSR);
  assign req_write = (req_kind == CYC_PROG) || (req_kind == CYC_ERASE);
  assign req_wren = req_write || (req_kind == CYC_WRSR);
  assign req_prot = req_write && (addr_reg >= PLO) && (addr_reg <= PHI);
  assign k_wren = (kind == CYC_PROG) || (kind == CYC_ERASE) || (kind == CYC_WRSR);
  assign k_addr = (kind == CYC_READ) || (kind == CYC_PROG) || (kind == CYC_ERASE);

  always_comb begin
    byte_state = 1'b1;
    tx_byte = 8'h00;
    case (state)
      S_WREN:  tx_byte = OP_WREN;
      S_CMD:   tx_byte = opcode_of(kind);
      S_ADDR:  tx_byte = addr_q[(ADDR_BYTES - 1 - int'(abyte)) * 8 +: 8];
      S_DOUT:  tx_byte = buf_q;
      S_PCMD:  tx_byte = OP_RDSR;
      S_DUMMY, S_DIN, S_PREAD: tx_byte = 8'h00;
      default: byte_state = 1'b0;
    endcase
  end

  assign launch = byte_state && !pend && !hold;

  flash_spi_shifter #(.W(8)) shifter_i (
    .clk(clk), .rst(rst), .start(launch), .tx(tx_byte), .miso(spi_miso),
    .done(sh_done), .rx(sh_rx), .sck(spi_sck), .mosi(spi_mosi)
  );

  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]       mem_wdata;

  assign mem_we    = busy ? (state == S_DIN && sh_done) : buf_wr;
  assign mem_waddr = busy ? idx : buf_idx;
  assign mem_wdata = busy ? sh_rx : buf_wdata;
  assign mem_raddr = busy ? idx : buf_idx;
  assign buf_rdata = buf_q;

  flash_data_buf #(.DEPTH(BUF_DEPTH), .W(8), .AW(IDX_W)) buf_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= CYC_READ;
      addr_reg <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      idx      <= '0;
      abyte    <= '0;
      poll_cnt <= '0;
      pend     <= 1'b0;
      hold     <= 1'b0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
      fcerr    <= 1'b0;
      ael      <= 1'b0;
    end else begin
      hold <= 1'b0;
      if (addr_wr) addr_reg <= addr_wdata;
      if (ctl_wr) begin
        if (ctl_wdata[CTL_CLR_DONE])  done  <= 1'b0;
        if (ctl_wdata[CTL_CLR_FCERR]) fcerr <= 1'b0;
        if (ctl_wdata[CTL_CLR_AEL])   ael   <= 1'b0;
      end
      if (launch) pend <= 1'b1;
      case (state)
        S_IDLE: if (go) begin
          kind     <= req_kind;
          addr_q   <= addr_reg;
          cnt_q    <= ctl_wdata[CTL_CNT_LSB +: IDX_W];
          idx      <= '0;
          abyte    <= '0;
          poll_cnt <= '0;
          if (!req_kind_ok) fcerr <= 1'b1;
          else if (req_prot) ael <= 1'b1;
          else begin
            spi_cs_n <= 1'b0;
            state    <= req_wren ? S_WREN : S_CMD;
          end
        end
        S_WREN: if (sh_done) begin
          pend     <= 1'b0;
          spi_cs_n <= 1'b1;
          state    <= S_GAP;
        end
        S_GAP: begin
          spi_cs_n <= 1'b0;
          state    <= S_CMD;
        end
        S_CMD: if (sh_done) begin
          pend <= 1'b0;
          if (k_addr) state <= S_ADDR;
          else if (kind == CYC_WRSR) state <= S_DOUT;
          else state <= S_DIN;
        end
        S_ADDR: if (sh_done) begin
          pend <= 1'b0;
          if (abyte == AB_W'(ADDR_BYTES - 1)) begin
            if (kind == CYC_READ) state <= S_DUMMY;
            else if (kind == CYC_PROG) state <= S_DOUT;
            else begin
              spi_cs_n <= 1'b1;
              state    <= S_END;
            end
          end else begin
            abyte <= abyte + AB_W'(1);
          end
        end
        S_DUMMY: if (sh_done) begin
          pend  <= 1'b0;
          state <= S_DIN;
        end
        S_DIN: if (sh_done) begin
          pend <= 1'b0;
          if (idx == cnt_q) begin
            spi_cs_n <= 1'b1;
            state    <= S_END;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_DOUT: if (sh_done) begin
          pend <= 1'b0;
          if (idx == cnt_q) begin
            spi_cs_n <= 1'b1;
            state    <= S_END;
          end else begin
            idx  <= idx + IDX_W'(1);
            hold <= 1'b1;
          end
        end
        S_END: begin
          if (k_wren) begin
            spi_cs_n <= 1'b0;
            state    <= S_PCMD;
          end else begin
            state <= S_FIN;
          end
        end
        S_PCMD: if (sh_done) begin
          pend  <= 1'b0;
          state <= S_PREAD;
        end
        S_PREAD: if (sh_done) begin
          pend <= 1'b0;
          if (!sh_rx[0]) begin
            spi_cs_n <= 1'b1;
            state    <= S_FIN;
          end else if (poll_cnt == PC_W'(POLL_MAX - 1)) begin
            spi_cs_n <= 1'b1;
            fcerr    <= 1'b1;
            state    <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + PC_W'(1);
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cycle_engine_chk.sv
module flash_cycle_engine_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ael,
  input logic spi_sck,
  input logic spi_cs_n
);
  // R13: serial clock pulses only inside a selected frame
  a_r13_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n);

  // R13: an idle engine leaves the bus deselected and quiet
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spi_cs_n && !spi_sck));

  // R8: a refused access never touches the bus or the busy state
  a_r8_ael_no_traffic: assert property (@(posedge clk) disable iff (rst)
    $rose(ael) |-> (spi_cs_n && !busy && $past(!busy)));

  // R4: completion is flagged only at the end of a run
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R13: the chip select never drops while idle
  a_r13_cs_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> busy);
endmodule

bind flash_cycle_engine flash_cycle_engine_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ael(ael),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n)
);

// File: tb/flash_cycle_engine_tb_top.sv
module flash_cycle_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        addr_wr = 1'b0;
  logic [23:0] addr_wdata = '0;
  logic        buf_wr = 1'b0;
  logic [5:0]  buf_idx = '0;
  logic [7:0]  buf_wdata = '0;
  logic [7:0]  buf_rdata;
  logic        busy, done, fcerr, ael;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cycle_engine #(.ADDR_W(24), .BUF_DEPTH(64), .POLL_MAX(POLLS),
    .PROT_LO(32'h800), .PROT_HI(32'hFFF)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .buf_wr(buf_wr),
    .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .busy(busy), .done(done), .fcerr(fcerr), .ael(ael),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // behavioural flash
  logic [7:0]  fm_mem [1024];
  logic [7:0]  fm_in = '0, fm_op = '0, fm_out = '0, fm_sreg = '0;
  logic [23:0] fm_addr = '0;
  int          fm_bits = 0, fm_bytes = 0, fm_busy = 0;
  logic        fm_wel = 1'b0, fm_stuck = 1'b0;
  logic [7:0]  frm_op [32];
  int          frm_len [32];
  int          nfrm = 0;

  always @(negedge spi_cs_n) begin
    fm_bits = 0;
    fm_bytes = 0;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    fm_in = {fm_in[6:0], spi_mosi};
    fm_bits++;
    if (fm_bits == 8) begin
      if (fm_bytes == 0) begin
        fm_op = fm_in;
        if (fm_in == 8'h06) fm_wel = 1'b1;
      end else if ((fm_op == 8'h0B || fm_op == 8'h02 || fm_op == 8'h20) && fm_bytes <= 3) begin
        fm_addr = {fm_addr[15:0], fm_in};
      end else if (fm_op == 8'h02 && fm_wel) begin
        fm_mem[(int'(fm_addr) + fm_bytes - 4) % 1024] = fm_in;
      end else if (fm_op == 8'h01 && fm_bytes == 1) begin
        fm_sreg = fm_in;
      end
      fm_bits = 0;
      fm_bytes++;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (fm_bits == 0) begin
      fm_out = 8'h00;
      if (fm_op == 8'h9F) fm_out = 8'hC0 + 8'(fm_bytes - 1);
      else if (fm_op == 8'h05) begin
        fm_out = {7'd0, (fm_busy > 0) || fm_stuck};
        if (fm_busy > 0) fm_busy--;
      end else if (fm_op == 8'h0B && fm_bytes >= 5)
        fm_out = fm_mem[(int'(fm_addr) + fm_bytes - 5) % 1024];
    end
    spi_miso = fm_out[7 - fm_bits];
  end

  always @(posedge spi_cs_n) begin
    if (fm_bytes > 0 && nfrm < 32) begin
      frm_op[nfrm] = fm_op;
      frm_len[nfrm] = fm_bytes;
      nfrm++;
    end
    if (fm_bytes > 0 && fm_wel && (fm_op == 8'h02 || fm_op == 8'h20 || fm_op == 8'h01)) begin
      fm_busy = 3;
      fm_wel = 1'b0;
      if (fm_op == 8'h20 && fm_addr[23:12] == 12'd0)
        for (int i = 0; i < 1024; i++) fm_mem[i] = 8'hFF;
    end
  end

  int checks = 0, fails = 0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [15:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic buf_put(input int i, input logic [7:0] d);
    @(negedge clk);
    buf_wr = 1'b1;
    buf_idx = 6'(i);
    buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic buf_get(input int i, output logic [7:0] d);
    @(negedge clk);
    buf_idx = 6'(i);
    @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      if (!busy) return;
      @(negedge clk);
    end
    chk("hang", 1, 0);
  endtask

  // start a cycle with all three flags cleared
  task automatic run(input int kind, input int cntm1, input logic [23:0] a);
    nfrm = 0;
    @(negedge clk);
    addr_wr = 1'b1;
    addr_wdata = a;
    @(negedge clk);
    addr_wr = 1'b0;
    ctl_write(16'hE001 | 16'(kind << 1) | 16'(cntm1 << 4));
    wait_idle();
  endtask

  task automatic frame(input string tag, input int n, input logic [7:0] op, input int len);
    chk({tag, " opcode"}, int'(frm_op[n]), int'(op));
    chk({tag, " length"}, frm_len[n], len);
  endtask

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) fm_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 flags", {done, fcerr, ael}, 0);
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sck", spi_sck, 0);

    // R6 read ID, 3 bytes
    run(3, 2, 24'h0);
    chk("R6 rdid frames", nfrm, 1);
    frame("R6 rdid", 0, 8'h9F, 4);
    for (int i = 0; i < 3; i++) begin
      buf_get(i, d);
      chk("R6 rdid data", d, 8'hC0 + i);
    end
    chk("R6 rdid done", done, 1);

    // R6 read status, 2 bytes
    run(5, 1, 24'h0);
    chk("R6 rdsr frames", nfrm, 1);
    frame("R6 rdsr", 0, 8'h05, 3);
    buf_get(0, d);
    chk("R6 rdsr data", d, 0);

    // R4 page write 4 bytes at 0x10
    for (int i = 0; i < 4; i++) buf_put(i, 8'hA0 + 8'(i * 17));
    run(1, 3, 24'h000010);
    chk("R4 frames", nfrm, 3);
    frame("R4 wren", 0, 8'h06, 1);
    frame("R4 prog", 1, 8'h02, 8);
    frame("R4 poll", 2, 8'h05, 5);
    chk("R4 done", done, 1);
    for (int i = 0; i < 4; i++) chk("R4 flash data", fm_mem[16 + i], 8'hA0 + i * 17);

    // R3 read back
    run(0, 3, 24'h000010);
    chk("R3 frames", nfrm, 1);
    frame("R3 read", 0, 8'h0B, 9);
    for (int i = 0; i < 4; i++) begin
      buf_get(i, d);
      chk("R3 read data", d, 8'hA0 + i * 17);
    end

    // R5 erase at 0
    run(2, 5, 24'h000000);
    chk("R5 frames", nfrm, 3);
    frame("R5 wren", 0, 8'h06, 1);
    frame("R5 erase", 1, 8'h20, 4);
    frame("R5 poll", 2, 8'h05, 5);
    chk("R5 erased", fm_mem[16], 8'hFF);
    chk("R5 done", done, 1);

    // R7 write status
    buf_put(0, 8'h5A);
    run(4, 0, 24'h0);
    chk("R7 frames", nfrm, 3);
    frame("R7 wren", 0, 8'h06, 1);
    frame("R7 wrsr", 1, 8'h01, 2);
    frame("R7 poll", 2, 8'h05, 5);
    chk("R7 value", fm_sreg, 8'h5A);

    // R8 protected window
    run(1, 0, 24'h000900);
    chk("R8 prog ael", ael, 1);
    chk("R8 prog done", done, 0);
    chk("R8 prog frames", nfrm, 0);
    run(2, 0, 24'h000800);
    chk("R8 erase low edge ael", ael, 1);
    chk("R8 erase frames", nfrm, 0);
    run(1, 0, 24'h000FFF);
    chk("R8 prog high edge ael", ael, 1);
    run(1, 0, 24'h0007FF);
    chk("R8 below window ael", ael, 0);
    chk("R8 below window frames", nfrm, 3);
    run(0, 0, 24'h000900);
    chk("R8 read in window ael", ael, 0);
    chk("R8 read in window done", done, 1);

    // R9 unsupported kinds
    run(6, 0, 24'h0);
    chk("R9 kind6 fcerr", fcerr, 1);
    chk("R9 kind6 frames", nfrm, 0);
    run(7, 0, 24'h0);
    chk("R9 kind7 fcerr", fcerr, 1);
    chk("R9 kind7 done", done, 0);

    // R10 poll timeout
    fm_stuck = 1'b1;
    run(1, 0, 24'h000020);
    chk("R10 fcerr", fcerr, 1);
    chk("R10 done", done, 0);
    chk("R10 poll length", frm_len[2], 1 + POLLS);
    chk("R10 cs_n", spi_cs_n, 1);
    fm_stuck = 1'b0;
    fm_busy = 0;

    // R11 flag clears
    run(3, 0, 24'h0);
    ctl_write(16'h4000);
    chk("R11 other flag kept", done, 1);
    ctl_write(16'h0000);
    chk("R11 zero keeps", done, 1);
    ctl_write(16'h2000);
    chk("R11 done cleared", done, 0);

    // R2 start and buffer writes ignored while busy
    buf_put(10, 8'h11);
    nfrm = 0;
    @(negedge clk);
    addr_wr = 1'b1;
    addr_wdata = 24'h000010;
    @(negedge clk);
    addr_wr = 1'b0;
    ctl_write(16'hE001 | 16'(3 << 4));
    repeat (20) @(negedge clk);
    ctl_write(16'h0007);
    buf_put(10, 8'h77);
    wait_idle();
    chk("R2 frames", nfrm, 1);
    chk("R2 kept opcode", frm_op[0], 8'h0B);
    buf_get(10, d);
    chk("R2 buffer untouched", d, 8'h11);

    // R12 full 64-byte write then every read length
    for (int i = 0; i < 64; i++) buf_put(i, 8'((i * 37 + 5) & 255));
    run(1, 63, 24'h000040);
    frame("R12 prog64", 1, 8'h02, 68);
    for (int n = 1; n <= 64; n++) begin
      int bad;
      bad = 0;
      run(0, n - 1, 24'h000040);
      chk("R12 read length", frm_len[0], 5 + n);
      for (int i = 0; i < n; i++) begin
        buf_get(i, d);
        if (d != 8'((i * 37 + 5) & 255)) bad++;
      end
      chk("R12 read data mismatches", bad, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule